// File: doc/BRIEF.md
# Reset-Configured Boot ROM Bus Slave

This block is a read-only slave on a 16-bit internal bus. It serves four bootstrap words that the processor fetches from the bottom of the address space while leaving reset. It also serves a program and data array whose contents are a constant computed at build time. The array occupies a power-of-two window that software may move. A small register block (a configuration word plus a high and a low base register) sits at a fixed word address and always answers, so software can reach it in any state.

While master reset is held, the block latches three straps from the data lines. These decide whether it starts stopped and whether emulation starts enabled. A stopped block answers neither the bootstrap range nor the array window, so an external responder can take those addresses. Software can later clear the stop and emulation bits by writing the configuration word. A lock bit freezes the base address. Once set, the lock bit can be removed only by master reset, which returns it to its build-time default. A build-time switch can keep the block from ever answering the bootstrap range.

Addresses are word addresses. Every response, acknowledge and read data together, is registered and appears one clock after the request.

Top module: `boot_rom_if`

## Requirements
- R1: While reset is low, STOP (config bit 0) is loaded with the inverse of strap bit 14. A strap of 1 leaves the block answering and a strap of 0 stops it.
- R2: While reset is low, EMUL (config bit 1) is set only if strap bits 13 and 10 are both 0, and is cleared otherwise. Output `emul_mode` follows EMUL.
- R3: While STOP is 1, reads and writes to the bootstrap range and the array window get no acknowledge. The register block still answers.
- R4: A write to the configuration word (register offset 0) loads STOP from data bit 0 and EMUL from data bit 1 at any time. A 1 on data bit 2 sets LOCK, and a 0 there does not clear it.
- R5: After reset, LOCK (config bit 2) equals its default. While LOCK is 1, writes to the base registers are acknowledged but leave the base unchanged.
- R6: Reads of word addresses 0 to 3 return bootstrap words 0 to 3 with an acknowledge one cycle after the request.
- R7: A read whose address bits above the window size equal those of the base address {high register, low register} returns array word (i*0x0107) xor 0xA5C3. Here i is the address offset within the window, and the result is truncated to 16 bits.
- R8: Writes to the bootstrap range or the array window get no acknowledge and change no stored value.
- R9: Register offset 0 reads {13'b0, LOCK, EMUL, STOP}, offset 1 reads the high base bits zero-extended, and offset 2 reads the low 16 base bits. Offset 3 gets no acknowledge.
- R10: Acknowledge is high for exactly the cycle after each mapped request and never without a request. Read data is zero whenever there is no acknowledge and for write acknowledges.
- R11: Where regions overlap, the register block wins over the bootstrap range, and the bootstrap range wins over the array window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Master reset, active low, synchronous |
| reset_straps | input | 16 | Data lines sampled as straps while reset is low |
| bus_req | input | 1 | Access request, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | 16 | Write data |
| bus_ack | output | 1 | Acknowledge, one cycle after a mapped request |
| bus_rdata | output | 16 | Read data, valid with bus_ack |
| emul_mode | output | 1 | Emulation mode flag |

## Verification
Every bus result is due exactly one rising edge after the request, both the acknowledge and the read data. A configuration write changes state at that same edge, so the next request already sees it. The bench drives each request on a falling edge and samples the response on the following falling edge, after the single register stage. One cycle later it confirms that the acknowledge has dropped. Strap effects are checked on the first cycle after reset is released, through `emul_mode` and a read of the configuration word.

// File: rtl/boot_rom_pkg.sv
package boot_rom_pkg;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_REG  = 2'd1,
    SEL_BOOT = 2'd2,
    SEL_ARR  = 2'd3
  } sel_e;

  typedef enum logic [1:0] {
    REG_CFG = 2'd0,
    REG_BHI = 2'd1,
    REG_BLO = 2'd2,
    REG_RSV = 2'd3
  } reg_e;

  // Strap decode: line 14 high keeps the block running.
  function automatic logic strap_stop(logic [15:0] d);
    return ~d[14];
  endfunction

  // Strap decode: emulation only when lines 13 and 10 are both low.
  function automatic logic strap_emul(logic [15:0] d);
    return ~(d[13] | d[10]);
  endfunction

  // Array content as a pure function of the word offset.
  function automatic logic [15:0] arr_word(logic [15:0] idx);
    logic [15:0] prod;
    prod = idx * 16'h0107;
    return prod ^ 16'hA5C3;
  endfunction

endpackage

// File: rtl/boot_rom_cfg.sv
module boot_rom_cfg
  import boot_rom_pkg::*;
#(
  parameter int              ADDR_W   = 20,
  parameter logic [ADDR_W-1:0] BASE_RST = '0,
  parameter bit              LOCK_RST = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [15:0]       strap,
  input  logic              wr_en,
  input  reg_e              wr_reg,
  input  logic [15:0]       wdata,
  output logic              stop_q,
  output logic              emul_q,
  output logic              lock_q,
  output logic [ADDR_W-1:0] base_q
);

  localparam int HI_W = ADDR_W - 16;

  logic [HI_W-1:0] hi_q;
  logic [15:0]     lo_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stop_q <= strap_stop(strap);
      emul_q <= strap_emul(strap);
      lock_q <= LOCK_RST;
      hi_q   <= BASE_RST[ADDR_W-1:16];
      lo_q   <= BASE_RST[15:0];
    end else if (wr_en) begin
      case (wr_reg)
        REG_CFG: begin
          stop_q <= wdata[0];
          emul_q <= wdata[1];
          lock_q <= lock_q | wdata[2];
        end
        REG_BHI: if (!lock_q) hi_q <= wdata[HI_W-1:0];
        REG_BLO: if (!lock_q) lo_q <= wdata;
        default: ;
      endcase
    end
  end

  assign base_q = {hi_q, lo_q};

endmodule

// File: rtl/boot_rom_decode.sv
module boot_rom_decode
  import boot_rom_pkg::*;
#(
  parameter int                ADDR_W   = 20,
  parameter int                ARR_AW   = 8,
  parameter logic [ADDR_W-1:0] REG_BASE = '0,
  parameter bit                BOOT_EN  = 1'b1
) (
  input  logic [ADDR_W-1:0]      addr,
  input  logic [ADDR_W-ARR_AW-1:0] base_top,
  input  logic                   stop,
  output sel_e                   sel,
  output reg_e                   reg_idx,
  output logic [1:0]             boot_idx,
  output logic [ARR_AW-1:0]      arr_idx
);

  logic reg_hit, boot_hit, arr_hit;

  assign reg_hit  = (addr[ADDR_W-1:2] == REG_BASE[ADDR_W-1:2]);
  assign boot_hit = BOOT_EN && (addr[ADDR_W-1:2] == '0);
  assign arr_hit  = (addr[ADDR_W-1:ARR_AW] == base_top);

  assign reg_idx  = reg_e'(addr[1:0]);
  assign boot_idx = addr[1:0];
  assign arr_idx  = addr[ARR_AW-1:0];

  always_comb begin
    if (reg_hit)               sel = SEL_REG;
    else if (stop)             sel = SEL_NONE;
    else if (boot_hit)         sel = SEL_BOOT;
    else if (arr_hit)          sel = SEL_ARR;
    else                       sel = SEL_NONE;
  end

endmodule

// File: rtl/boot_rom_array.sv
module boot_rom_array
  import boot_rom_pkg::*;
#(
  parameter int ARR_AW = 8
) (
  input  logic [ARR_AW-1:0] idx,
  output logic [15:0]       word
);

  logic [15:0] ext;

  generate
    if (ARR_AW >= 16) begin : g_wide
      assign ext = idx[15:0];
    end else begin : g_narrow
      assign ext = {{(16-ARR_AW){1'b0}}, idx};
    end
  endgenerate

  assign word = arr_word(ext);

endmodule

// File: rtl/boot_rom_if.sv
module boot_rom_if
  import boot_rom_pkg::*;
#(
  parameter int                ADDR_W   = 20,
  parameter int                ARR_AW   = 8,
  parameter logic [ADDR_W-1:0] REG_BASE = 20'hFF800,
  parameter logic [ADDR_W-1:0] BASE_RST = 20'h01000,
  parameter bit                BOOT_EN  = 1'b1,
  parameter bit                LOCK_RST = 1'b0,
  parameter logic [15:0]       BOOT_W0  = 16'h2700,
  parameter logic [15:0]       BOOT_W1  = 16'h0000,
  parameter logic [15:0]       BOOT_W2  = 16'h0001,
  parameter logic [15:0]       BOOT_W3  = 16'h0F00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [15:0]       reset_straps,
  input  logic              bus_req,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [15:0]       bus_wdata,
  output logic              bus_ack,
  output logic [15:0]       bus_rdata,
  output logic              emul_mode
);

  localparam int HI_W  = ADDR_W - 16;
  localparam int TOP_W = ADDR_W - ARR_AW;

  function automatic logic [15:0] boot_word(logic [1:0] i);
    case (i)
      2'd0:    return BOOT_W0;
      2'd1:    return BOOT_W1;
      2'd2:    return BOOT_W2;
      default: return BOOT_W3;
    endcase
  endfunction

  logic              stop_q, emul_q, lock_q;
  logic [ADDR_W-1:0] base_q;
  sel_e              sel;
  reg_e              reg_idx;
  logic [1:0]        boot_idx;
  logic [ARR_AW-1:0] arr_idx;
  logic [15:0]       arr_data;
  logic              reg_wr;
  logic              nxt_ack;
  logic [15:0]       nxt_data;
  logic [15:0]       reg_val;

  boot_rom_decode #(
    .ADDR_W  (ADDR_W),
    .ARR_AW  (ARR_AW),
    .REG_BASE(REG_BASE),
    .BOOT_EN (BOOT_EN)
  ) u_dec (
    .addr    (bus_addr),
    .base_top(base_q[ADDR_W-1:ARR_AW]),
    .stop    (stop_q),
    .sel     (sel),
    .reg_idx (reg_idx),
    .boot_idx(boot_idx),
    .arr_idx (arr_idx)
  );

  assign reg_wr = bus_req && bus_wr && (sel == SEL_REG) && (reg_idx != REG_RSV);

  boot_rom_cfg #(
    .ADDR_W  (ADDR_W),
    .BASE_RST(BASE_RST),
    .LOCK_RST(LOCK_RST)
  ) u_cfg (
    .clk   (clk),
    .rst_n (rst_n),
    .strap (reset_straps),
    .wr_en (reg_wr),
    .wr_reg(reg_idx),
    .wdata (bus_wdata),
    .stop_q(stop_q),
    .emul_q(emul_q),
    .lock_q(lock_q),
    .base_q(base_q)
  );

  boot_rom_array #(.ARR_AW(ARR_AW)) u_arr (
    .idx (arr_idx),
    .word(arr_data)
  );

  always_comb begin
    case (reg_idx)
      REG_CFG: reg_val = {13'b0, lock_q, emul_q, stop_q};
      REG_BHI: reg_val = {{(16-HI_W){1'b0}}, base_q[ADDR_W-1:16]};
      REG_BLO: reg_val = base_q[15:0];
      default: reg_val = '0;
    endcase
  end

  always_comb begin
    nxt_ack  = 1'b0;
    nxt_data = '0;
    if (bus_req) begin
      case (sel)
        SEL_REG: begin
          nxt_ack  = (reg_idx != REG_RSV);
          nxt_data = (bus_wr || reg_idx == REG_RSV) ? 16'h0 : reg_val;
        end
        SEL_BOOT: begin
          nxt_ack  = !bus_wr;
          nxt_data = bus_wr ? 16'h0 : boot_word(boot_idx);
        end
        SEL_ARR: begin
          nxt_ack  = !bus_wr;
          nxt_data = bus_wr ? 16'h0 : arr_data;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_ack   <= 1'b0;
      bus_rdata <= '0;
    end else begin
      bus_ack   <= nxt_ack;
      bus_rdata <= nxt_data;
    end
  end

  assign emul_mode = emul_q;

  // Unused-width guard: TOP_W must leave a nonempty compare field.
  initial begin
    if (TOP_W < 1 || HI_W < 1) $error("boot_rom_if: bad ADDR_W/ARR_AW");
  end

endmodule

// File: rtl/boot_rom_if_chk.sv
module boot_rom_if_chk
  import boot_rom_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_req,
  input logic              bus_wr,
  input logic              bus_ack,
  input logic              emul_mode,
  input logic              stop_q,
  input logic              lock_q,
  input logic [ADDR_W-1:0] base_q,
  input sel_e              sel
);

  p_ack_needs_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ack |-> $past(bus_req));

  p_stop_silences_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && stop_q && sel != SEL_REG) |=> !bus_ack);

  p_cfg_write_sets_emul_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(emul_mode) |-> $past(bus_req && bus_wr));

  p_lock_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> lock_q);

  p_lock_base_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> $stable(base_q));

  p_boot_read_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_wr && sel == SEL_BOOT) |=> bus_ack);

  p_arr_read_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_wr && sel == SEL_ARR) |=> bus_ack);

  p_rom_write_nack_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_wr && sel != SEL_REG) |=> !bus_ack);

endmodule

bind boot_rom_if boot_rom_if_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_req  (bus_req),
  .bus_wr   (bus_wr),
  .bus_ack  (bus_ack),
  .emul_mode(emul_mode),
  .stop_q   (stop_q),
  .lock_q   (lock_q),
  .base_q   (base_q),
  .sel      (sel)
);

// File: tb/boot_rom_if_bench.sv
`timescale 1ns/1ps
module boot_rom_if_bench;

  localparam logic [19:0] REGB  = 20'hFF800;
  localparam logic [19:0] BASE0 = 20'h01000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] reset_straps = 16'h4000;
  logic        bus_req = 1'b0;
  logic        bus_wr = 1'b0;
  logic [19:0] bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic        bus_ack;
  logic [15:0] bus_rdata;
  logic        emul_mode;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic        m_stop, m_emul, m_lock;
  logic [19:0] m_base;

  always #2 clk = ~clk;

  boot_rom_if u_boot_rom_if (
    .clk(clk), .rst_n(rst_n), .reset_straps(reset_straps),
    .bus_req(bus_req), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_rdata(bus_rdata),
    .emul_mode(emul_mode)
  );

  function automatic logic [15:0] exp_boot(logic [1:0] i);
    logic [15:0] t [4];
    t = '{16'h2700, 16'h0000, 16'h0001, 16'h0F00};
    return t[i];
  endfunction

  // Same array rule written as shifts and adds.
  function automatic logic [15:0] exp_arr(logic [7:0] i);
    logic [31:0] v;
    v = ({24'b0, i} << 8) + ({24'b0, i} << 2) + ({24'b0, i} << 1) + {24'b0, i};
    return v[15:0] ^ 16'hA5C3;
  endfunction

  task automatic predict(input logic wr, input logic [19:0] a,
                         output logic ack, output logic [15:0] d);
    ack = 1'b0; d = 16'h0;
    if (a[19:2] == REGB[19:2]) begin
      ack = (a[1:0] != 2'd3);
      if (!wr && a[1:0] == 2'd0) d = {13'b0, m_lock, m_emul, m_stop};
      if (!wr && a[1:0] == 2'd1) d = {12'b0, m_base[19:16]};
      if (!wr && a[1:0] == 2'd2) d = m_base[15:0];
    end else if (m_stop) begin
      ack = 1'b0;
    end else if (a < 20'd4) begin
      ack = !wr; d = wr ? 16'h0 : exp_boot(a[1:0]);
    end else if (a[19:8] == m_base[19:8]) begin
      ack = !wr; d = wr ? 16'h0 : exp_arr(a[7:0]);
    end
  endtask

  task automatic model_write(input logic [19:0] a, input logic [15:0] wd);
    if (a[19:2] == REGB[19:2]) begin
      case (a[1:0])
        2'd0: begin m_stop = wd[0]; m_emul = wd[1]; m_lock = m_lock | wd[2]; end
        2'd1: if (!m_lock) m_base[19:16] = wd[3:0];
        2'd2: if (!m_lock) m_base[15:0] = wd;
        default: ;
      endcase
    end
  endtask

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic acc(input logic wr, input logic [19:0] a, input logic [15:0] wd, input string tag);
    logic eack;
    logic [15:0] ed;
    predict(wr, a, eack, ed);
    @(negedge clk);
    bus_req = 1'b1; bus_wr = wr; bus_addr = a; bus_wdata = wd;
    @(negedge clk);
    bus_req = 1'b0; bus_wr = 1'b0;
    chk(bus_ack === eack && bus_rdata === ed, tag, {15'b0, bus_ack, bus_rdata}, {15'b0, eack, ed});
    if (wr) model_write(a, wd);
    @(negedge clk);
    chk(bus_ack === 1'b0 && bus_rdata === 16'h0, "R10 ack drops", {15'b0, bus_ack, bus_rdata}, 32'h0);
  endtask

  task automatic reset_with(input logic [15:0] s);
    @(negedge clk);
    rst_n = 1'b0; reset_straps = s;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    reset_straps = ~s;
    m_stop = ~s[14]; m_emul = ~(s[13] | s[10]); m_lock = 1'b0; m_base = BASE0;
    chk(emul_mode === m_emul, "R2 emul after reset", {31'b0, emul_mode}, {31'b0, m_emul});
    chk(bus_ack === 1'b0, "R10 no ack at reset", {31'b0, bus_ack}, 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED));

    // Strap 14 high, 13 high: running, no emulation.
    reset_with(16'h6000);
    acc(1'b0, REGB + 0, 16'h0, "R1 R9 cfg read");
    acc(1'b0, REGB + 1, 16'h0, "R9 base hi read");
    acc(1'b0, REGB + 2, 16'h0, "R9 base lo read");
    acc(1'b0, REGB + 3, 16'h0, "R9 reserved nack");
    for (int i = 0; i < 4; i++) acc(1'b0, 20'(i), 16'h0, "R6 boot word");
    for (int i = 0; i < 12; i++) acc(1'b0, {BASE0[19:8], 8'($urandom)}, 16'h0, "R7 array read");
    acc(1'b0, 20'h010FF, 16'h0, "R7 window top");
    acc(1'b0, 20'h01100, 16'h0, "R7 past window");

    // Writes into read-only space.
    acc(1'b1, 20'd1, 16'hDEAD, "R8 boot write nack");
    acc(1'b0, 20'd1, 16'h0, "R8 boot word unchanged");
    acc(1'b1, 20'h01010, 16'hBEEF, "R8 array write nack");
    acc(1'b0, 20'h01010, 16'h0, "R8 array word unchanged");

    // Move window.
    acc(1'b1, REGB + 1, 16'h0002, "R7 write hi");
    acc(1'b1, REGB + 2, 16'h3400, "R7 write lo");
    acc(1'b0, 20'h23455, 16'h0, "R7 moved window hit");
    acc(1'b0, 20'h01055, 16'h0, "R7 old window miss");

    // Overlap: base at zero.
    acc(1'b1, REGB + 1, 16'h0000, "R11 hi zero");
    acc(1'b1, REGB + 2, 16'h0000, "R11 lo zero");
    acc(1'b0, 20'd2, 16'h0, "R11 boot wins");
    acc(1'b0, 20'd10, 16'h0, "R11 array below");

    // Lock.
    acc(1'b1, REGB + 0, 16'h0004, "R4 set lock");
    acc(1'b1, REGB + 2, 16'h5500, "R5 locked lo write");
    acc(1'b1, REGB + 1, 16'h0007, "R5 locked hi write");
    acc(1'b0, REGB + 2, 16'h0, "R5 lo unchanged");
    acc(1'b0, REGB + 1, 16'h0, "R5 hi unchanged");
    acc(1'b1, REGB + 0, 16'h0000, "R4 lock not cleared");
    acc(1'b0, REGB + 0, 16'h0, "R4 lock still set");

    // Software stop.
    acc(1'b1, REGB + 0, 16'h0001, "R4 set stop");
    acc(1'b0, 20'd0, 16'h0, "R3 boot silent");
    acc(1'b0, 20'd20, 16'h0, "R3 array silent");
    acc(1'b0, REGB + 0, 16'h0, "R3 regs answer");
    acc(1'b1, REGB + 0, 16'h0002, "R4 clear stop set emul");
    chk(emul_mode === 1'b1, "R4 emul by write", {31'b0, emul_mode}, 32'h1);
    acc(1'b0, 20'd3, 16'h0, "R4 boot back");

    // All straps low: stopped, emulation on, lock back to default, base back.
    reset_with(16'h0000);
    acc(1'b0, REGB + 0, 16'h0, "R1 R2 R5 cfg after reset");
    acc(1'b0, 20'd0, 16'h0, "R1 stopped boot");
    acc(1'b0, 20'h01000, 16'h0, "R1 stopped array");
    acc(1'b0, REGB + 2, 16'h0, "R5 base reset");
    acc(1'b1, REGB + 0, 16'h0000, "R4 clear all");
    chk(emul_mode === 1'b0, "R4 emul cleared", {31'b0, emul_mode}, 32'h0);
    acc(1'b0, 20'd1, 16'h0, "R4 boot after clear");

    reset_with(16'h4400);
    acc(1'b0, REGB + 0, 16'h0, "R2 strap10 blocks emul");
    reset_with(16'h2000);
    acc(1'b0, REGB + 0, 16'h0, "R1 strap14 low stops");

    // Random traffic.
    reset_with(16'h6000);
    for (int k = 0; k < 300; k++) begin
      int c;
      c = int'($urandom_range(0, 5));
      case (c)
        0: acc(1'b0, 20'($urandom_range(0, 3)), 16'h0, "R6 rand boot");
        1: acc(1'b0, {m_base[19:8], 8'($urandom)}, 16'h0, "R7 rand array");
        2: acc(1'b0, 20'($urandom), 16'h0, "R10 rand addr");
        3: acc(1'b1, {m_base[19:8], 8'($urandom)}, 16'($urandom), "R8 rand array write");
        4: acc(1'b1, REGB + 0, {14'b0, 1'($urandom), 1'($urandom_range(0, 3) == 0)}, "R4 rand cfg");
        default: acc(1'b0, REGB + 20'($urandom_range(0, 3)), 16'h0, "R9 rand reg read");
      endcase
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule